// File: doc/BRIEF.md
# Page Access Rights and Fault Checker

This block takes the fields of an already matched translation entry together with the state of the current access. From them it works out which permissions the access may use and which fault, if any, it raises. The entry fields it uses are:

- a 3-bit rights type;
- two privilege bounds (a read bound and a write bound);
- an access identifier;
- a dirty flag, a break flag and a reference-trap flag.

The access state is a hit flag, the current privilege, a protection-check enable, a set of protection identifiers and a wide-mode flag. The access kind is probe, read, write or execute.

The result is a 3-bit permission mask and a 4-bit fault code. The mask is narrowed by every condition that should force a later access to re-check the entry. Faults are resolved so that the highest-priority condition wins: the reference trap beats break, and break beats dirty. The entry storage and the address arithmetic sit elsewhere.

With `REGISTERED=1` (the default) both results are registered and appear one clock after the inputs. With `REGISTERED=0` they are combinational.

Top module: `page_rights_checker`

## Requirements
- R1: Let privilege p, read bound a and write bound b be unsigned 2-bit numbers. Read is allowed when p <= a, write when p <= b, and execute when b <= p <= a.
- R2: The mask is bit0=read, bit1=write, bit2=execute. Rights type 0 keeps read; 1 keeps read and write; 2 keeps read and execute; 3 keeps all three; types 4 to 7 keep execute only.
- R3: The access kind is 0=probe, 1=read, 2=write, 3=execute. With hit low the mask is 0. The fault is 1 (instruction miss) for execute and 2 (data miss) for any other kind, probe included.
- R4: A hit probe gives fault 0 and the unmodified R1/R2 mask, whatever the identifier, dirty, break and trap inputs are.
- R5: The identifier check is skipped when the entry's access identifier is all zero or the check enable is low.
- R6: Each identifier field is 17 bits: bits 16:1 are the key and bit 0 is write-disable. Slot j sits at bits [17j+16:17j] of `pidIds`. A field matches when its key equals the low 16 bits of the access identifier, and the lowest-ordered enabled match wins. A match allows read and execute, plus write when write-disable is 0.
- R7: Slots 2i and 2i+1 are the low and high identifiers of register i. In wide mode the order is 0,1,2,...,7. In narrow mode only the even slots take part.
- R8: When the identifier check is active and no match allows the requested kind, the fault is 3 for execute and 4 for other kinds, and the mask is the R1/R2 mask.
- R9: Otherwise the mask is ANDed with the matching identifier's permissions (when the check is active). If the result lacks the requested bit, the fault is 3 for execute and 5 otherwise, with that ANDed mask.
- R10: After R9 passes, a clear dirty flag removes write from the mask and gives fault 6 on a write.
- R11: A set break flag then removes write and gives fault 7 on a write, overriding fault 6.
- R12: A set reference trap then leaves only execute in the mask and gives fault 8 on any non-execute kind, overriding faults 6 and 7.
- R13: With REGISTERED=1 the results appear one clock after the inputs, and an active-low reset clears the mask and fault to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hit | input | 1 | Entry matched the address |
| accKind | input | 2 | 0 probe, 1 read, 2 write, 3 execute |
| curPriv | input | 2 | Current privilege level |
| pidCheckEn | input | 1 | Protection identifier check enable |
| wideMode | input | 1 | Two identifiers per register |
| entRights | input | 3 | Entry rights type |
| entPlRead | input | 2 | Entry read privilege bound |
| entPlWrite | input | 2 | Entry write privilege bound |
| entAccessId | input | AID_W (31) | Entry access identifier |
| entDirty | input | 1 | Entry dirty flag |
| entBreak | input | 1 | Entry break flag |
| entRefTrap | input | 1 | Entry reference-trap flag |
| pidIds | input | NUM_PID*2*17 (136) | Packed identifier fields |
| grantMask | output | 3 | Granted permissions |
| faultCode | output | 4 | Fault code, 0 for none |

## Verification
The bench targets the fault override chain. It writes with dirty clear, with break set and with the trap set, all together. A design that kept the first fault found would report 6 where 8 is due.

It places one identifier in the high half of register 0 and a different one in register 1. A checker that ignored the high half in wide mode, or honoured it in narrow mode, would pick the wrong write-disable.

It also sends probes and misses with faulty entry flags. A design that did not let probes bypass the checks would report faults on them. A design that treated a probe miss as an instruction miss would report 1 instead of 2.

A randomized run compares every result against a model built from the requirements, covering the privilege window edges where read, write and execute part ways.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    KIND_PROBE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_EXEC  = 2'd3
  } accKindT;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_IPROT   = 4'd3,
    FLT_DPID    = 4'd4,
    FLT_DRIGHTS = 4'd5,
    FLT_DIRTY   = 4'd6,
    FLT_BREAK   = 4'd7,
    FLT_PAGEREF = 4'd8
  } faultT;

  localparam int MASK_R = 0;
  localparam int MASK_W = 1;
  localparam int MASK_X = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic       probe;
    logic       isWrite;
    logic       isExec;
    logic       pidActive;
    logic [2:0] reqMask;
  } ctrlStrobeT;

endpackage

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int AID_W = 31
) (
  input  logic [1:0]       accKind,
  input  logic             pidCheckEn,
  input  logic [AID_W-1:0] accessId,
  output ctrlStrobeT       strobes
);

  accKindT kind;

  always_comb begin
    kind              = accKindT'(accKind);
    strobes           = '0;
    strobes.probe     = (kind == KIND_PROBE);
    strobes.isWrite   = (kind == KIND_WRITE);
    strobes.isExec    = (kind == KIND_EXEC);
    strobes.pidActive = pidCheckEn && (accessId != '0);
    unique case (kind)
      KIND_READ:  strobes.reqMask = 3'b001;
      KIND_WRITE: strobes.reqMask = 3'b010;
      KIND_EXEC:  strobes.reqMask = 3'b100;
      default:    strobes.reqMask = 3'b000;
    endcase
  end

endmodule

// File: rtl/pac_pid_match.sv
module pac_pid_match #(
  parameter int NUM_PID = 4,
  parameter int MATCH_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_PID*2*(MATCH_W+1)-1:0]   pidIds,
  input  logic                               wideMode,
  input  logic [MATCH_W-1:0]                 accessKey,
  output logic                               idHit,
  output logic                               idWriteDis
);

  localparam int SLOTS = NUM_PID * 2;
  localparam int FLD_W = MATCH_W + 1;

  function automatic logic [SLOTS-1:0] loMaskF();
    logic [SLOTS-1:0] m;
    m = '0;
    for (int j = 0; j < SLOTS; j += 2) m[j] = 1'b1;
    return m;
  endfunction

  localparam logic [SLOTS-1:0] LO_MASK = loMaskF();

  logic [SLOTS-1:0] slotHit;
  logic [SLOTS-1:0] slotWd;

  generate
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      localparam bit IS_HI = (j % 2) == 1;
      logic [FLD_W-1:0] field;
      logic             slotEn;
      assign field      = pidIds[j*FLD_W +: FLD_W];
      assign slotEn     = IS_HI ? wideMode : 1'b1;
      assign slotHit[j] = slotEn && (field[FLD_W-1:1] == accessKey);
      assign slotWd[j]  = field[0];
    end
  endgenerate

  // lowest slot index wins
  always_comb begin
    idHit      = 1'b0;
    idWriteDis = 1'b0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (slotHit[j]) begin
        idHit      = 1'b1;
        idWriteDis = slotWd[j];
      end
    end
  end

  // R7
  narrow_lo_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idHit && !wideMode) |-> ((slotHit & LO_MASK) != '0));

endmodule

// File: rtl/pac_datapath.sv
module pac_datapath
  import pac_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic              hit,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic [2:0]        entRights,
  input  logic [PRIV_W-1:0] plRead,
  input  logic [PRIV_W-1:0] plWrite,
  input  logic              dirty,
  input  logic              brk,
  input  logic              refTrap,
  input  logic              idHit,
  input  logic              idWriteDis,
  output logic [2:0]        resMask,
  output faultT             resFault
);

  logic       rdOk, wrOk, exOk;
  logic [2:0] rawMask, allowMask, narrowMask;

  // privilege window
  always_comb begin
    rdOk = (curPriv <= plRead);
    wrOk = (curPriv <= plWrite);
    exOk = (plWrite <= curPriv) && (curPriv <= plRead);
  end

  // rights type decode
  always_comb begin
    unique case (entRights)
      3'd0:    rawMask = {1'b0, 1'b0, rdOk};
      3'd1:    rawMask = {1'b0, wrOk, rdOk};
      3'd2:    rawMask = {exOk, 1'b0, rdOk};
      3'd3:    rawMask = {exOk, wrOk, rdOk};
      default: rawMask = {exOk, 1'b0, 1'b0};
    endcase
  end

  always_comb begin
    allowMask  = idHit ? (idWriteDis ? 3'b101 : 3'b111) : 3'b000;
    narrowMask = strobes.pidActive ? (rawMask & allowMask) : rawMask;
  end

  // fault resolution, later checks override earlier ones
  always_comb begin
    resMask  = rawMask;
    resFault = FLT_NONE;
    if (!hit) begin
      resMask  = 3'b000;
      resFault = strobes.isExec ? FLT_IMISS : FLT_DMISS;
    end else if (strobes.probe) begin
      resMask = rawMask;
    end else if (strobes.pidActive && ((allowMask & strobes.reqMask) == 3'b000)) begin
      resFault = strobes.isExec ? FLT_IPROT : FLT_DPID;
    end else if ((narrowMask & strobes.reqMask) == 3'b000) begin
      resMask  = narrowMask;
      resFault = strobes.isExec ? FLT_IPROT : FLT_DRIGHTS;
    end else begin
      resMask = narrowMask;
      if (!dirty) begin
        if (strobes.isWrite) resFault = FLT_DIRTY;
        resMask[MASK_W] = 1'b0;
      end
      if (brk) begin
        if (strobes.isWrite) resFault = FLT_BREAK;
        resMask[MASK_W] = 1'b0;
      end
      if (refTrap) begin
        if (!strobes.isExec) resFault = FLT_PAGEREF;
        resMask = resMask & 3'b100;
      end
    end
  end

  // R1
  exec_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && strobes.probe && resMask[MASK_X]) |-> (plWrite <= curPriv && curPriv <= plRead));

  // R3
  miss_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (resMask == 3'b000 && (resFault == FLT_IMISS || resFault == FLT_DMISS)));

  // R4
  probe_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && strobes.probe) |-> (resFault == FLT_NONE));

  // R9
  granted_covers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !strobes.probe && resFault == FLT_NONE) |-> ((resMask & strobes.reqMask) != 3'b000));

  // R10 R11
  write_only_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resFault == FLT_DIRTY || resFault == FLT_BREAK) |-> strobes.isWrite);

  // R12
  ref_trap_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !strobes.probe && refTrap && (resFault == FLT_NONE || resFault == FLT_PAGEREF))
      |-> (resMask[MASK_R] == 1'b0 && resMask[MASK_W] == 1'b0));

endmodule

// File: rtl/page_rights_checker.sv
module page_rights_checker
  import pac_pkg::*;
#(
  parameter int NUM_PID    = 4,
  parameter int MATCH_W    = 16,
  parameter int AID_W      = 31,
  parameter int PRIV_W     = 2,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             hit,
  input  logic [1:0]                       accKind,
  input  logic [PRIV_W-1:0]                curPriv,
  input  logic                             pidCheckEn,
  input  logic                             wideMode,
  input  logic [2:0]                       entRights,
  input  logic [PRIV_W-1:0]                entPlRead,
  input  logic [PRIV_W-1:0]                entPlWrite,
  input  logic [AID_W-1:0]                 entAccessId,
  input  logic                             entDirty,
  input  logic                             entBreak,
  input  logic                             entRefTrap,
  input  logic [NUM_PID*2*(MATCH_W+1)-1:0] pidIds,
  output logic [2:0]                       grantMask,
  output logic [3:0]                       faultCode
);

  ctrlStrobeT strobes;
  logic       idHit, idWriteDis;
  logic [2:0] resMask;
  faultT      resFault;

  pac_ctrl #(.AID_W(AID_W)) ctrl_i (
    .accKind    (accKind),
    .pidCheckEn (pidCheckEn),
    .accessId   (entAccessId),
    .strobes    (strobes)
  );

  pac_pid_match #(.NUM_PID(NUM_PID), .MATCH_W(MATCH_W)) match_i (
    .clk        (clk),
    .rstN       (rstN),
    .pidIds     (pidIds),
    .wideMode   (wideMode),
    .accessKey  (entAccessId[MATCH_W-1:0]),
    .idHit      (idHit),
    .idWriteDis (idWriteDis)
  );

  pac_datapath #(.PRIV_W(PRIV_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .hit        (hit),
    .curPriv    (curPriv),
    .entRights  (entRights),
    .plRead     (entPlRead),
    .plWrite    (entPlWrite),
    .dirty      (entDirty),
    .brk        (entBreak),
    .refTrap    (entRefTrap),
    .idHit      (idHit),
    .idWriteDis (idWriteDis),
    .resMask    (resMask),
    .resFault   (resFault)
  );

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          grantMask <= 3'b000;
          faultCode <= 4'd0;
        end else begin
          grantMask <= resMask;
          faultCode <= resFault;
        end
      end
    end else begin : g_comb
      assign grantMask = resMask;
      assign faultCode = resFault;
    end
  endgenerate

endmodule

// File: tb/page_rights_checker_tb.sv
module page_rights_checker_tb_top;

  localparam int FLD_W = 17;
  localparam int SLOTS = 8;

  typedef struct {
    logic                   hit;
    logic [1:0]             kind;
    logic [1:0]             priv;
    logic                   en;
    logic                   wide;
    logic [2:0]             typ;
    logic [1:0]             pl1;
    logic [1:0]             pl2;
    logic [30:0]            aid;
    logic                   d, b, t;
    logic [SLOTS*FLD_W-1:0] ids;
  } vecT;

  typedef struct {
    logic [2:0] m;
    logic [3:0] f;
    string      tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hit, pidCheckEn, wideMode, entDirty, entBreak, entRefTrap;
  logic [1:0] accKind, curPriv, entPlRead, entPlWrite;
  logic [2:0] entRights;
  logic [30:0] entAccessId;
  logic [SLOTS*FLD_W-1:0] pidIds;
  logic [2:0] grantMask;
  logic [3:0] faultCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit doneFlag = 0;
  expT q[$];

  always #2.5 clk = ~clk;

  page_rights_checker dut_i (
    .clk(clk), .rstN(rstN), .hit(hit), .accKind(accKind), .curPriv(curPriv),
    .pidCheckEn(pidCheckEn), .wideMode(wideMode), .entRights(entRights),
    .entPlRead(entPlRead), .entPlWrite(entPlWrite), .entAccessId(entAccessId),
    .entDirty(entDirty), .entBreak(entBreak), .entRefTrap(entRefTrap),
    .pidIds(pidIds), .grantMask(grantMask), .faultCode(faultCode)
  );

  function automatic expT model(vecT v);
    expT e;
    logic r, w, x, found, wd;
    logic [2:0] raw, req, allow, m;
    logic [FLD_W-1:0] fld;
    r = v.priv <= v.pl1;
    w = v.priv <= v.pl2;
    x = (v.pl2 <= v.priv) && (v.priv <= v.pl1);
    case (v.typ)
      3'd0: raw = {1'b0, 1'b0, r};
      3'd1: raw = {1'b0, w, r};
      3'd2: raw = {x, 1'b0, r};
      3'd3: raw = {x, w, r};
      default: raw = {x, 1'b0, 1'b0};
    endcase
    req = (v.kind == 2'd1) ? 3'b001 : (v.kind == 2'd2) ? 3'b010 : (v.kind == 2'd3) ? 3'b100 : 3'b000;
    e.tag = "R1";
    if (!v.hit) begin
      e.m = 3'b000; e.f = (v.kind == 2'd3) ? 4'd1 : 4'd2; e.tag = "R3"; return e;
    end
    if (v.kind == 2'd0) begin
      e.m = raw; e.f = 4'd0; e.tag = "R4"; return e;
    end
    m = raw;
    if (v.en && v.aid != 31'd0) begin
      found = 1'b0; wd = 1'b0;
      for (int i = 0; i < 4; i++) begin
        for (int h = 0; h < 2; h++) begin
          fld = v.ids[(2*i+h)*FLD_W +: FLD_W];
          if (!found && (h == 0 || v.wide) && fld[16:1] == v.aid[15:0]) begin
            found = 1'b1; wd = fld[0];
          end
        end
      end
      allow = found ? (wd ? 3'b101 : 3'b111) : 3'b000;
      if ((allow & req) == 3'b000) begin
        e.m = raw; e.f = (v.kind == 2'd3) ? 4'd3 : 4'd4; e.tag = "R8"; return e;
      end
      m = raw & allow;
    end
    if ((m & req) == 3'b000) begin
      e.m = m; e.f = (v.kind == 2'd3) ? 4'd3 : 4'd5; e.tag = "R9"; return e;
    end
    e.f = 4'd0;
    if (!v.d) begin
      if (v.kind == 2'd2) begin e.f = 4'd6; e.tag = "R10"; end
      m[1] = 1'b0;
    end
    if (v.b) begin
      if (v.kind == 2'd2) begin e.f = 4'd7; e.tag = "R11"; end
      m[1] = 1'b0;
    end
    if (v.t) begin
      if (v.kind != 2'd3) begin e.f = 4'd8; e.tag = "R12"; end
      m = m & 3'b100;
    end
    e.m = m;
    return e;
  endfunction

  function automatic vecT baseVec();
    vecT v;
    v.hit = 1; v.kind = 2'd1; v.priv = 2'd0; v.en = 0; v.wide = 0;
    v.typ = 3'd3; v.pl1 = 2'd3; v.pl2 = 2'd3; v.aid = 31'd0;
    v.d = 1; v.b = 0; v.t = 0;
    v.ids = {SLOTS{17'h0AAAA}};
    return v;
  endfunction

  function automatic vecT setId(vecT v, int slot, logic [15:0] key, logic wd);
    v.ids[slot*FLD_W +: FLD_W] = {key, wd};
    return v;
  endfunction

  task automatic apply(vecT v, string tag);
    expT e;
    @(negedge clk);
    hit = v.hit; accKind = v.kind; curPriv = v.priv; pidCheckEn = v.en;
    wideMode = v.wide; entRights = v.typ; entPlRead = v.pl1; entPlWrite = v.pl2;
    entAccessId = v.aid; entDirty = v.d; entBreak = v.b; entRefTrap = v.t;
    pidIds = v.ids;
    e = model(v);
    if (tag != "") e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: one result per cycle, sampled after the registering edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && q.size() > 0) begin
        expT e;
        e = q.pop_front();
        total++;
        if (grantMask !== e.m || faultCode !== e.f) begin
          bad++;
          $display("FAIL %s: mask=%b fault=%0d expected mask=%b fault=%0d",
                   e.tag, grantMask, faultCode, e.m, e.f);
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        finishRun();
      end
    end
  end

  initial begin
    vecT v;
    hit = 1; accKind = 2'd1; curPriv = 0; pidCheckEn = 0; wideMode = 0;
    entRights = 3'd3; entPlRead = 0; entPlWrite = 0; entAccessId = 0;
    entDirty = 1; entBreak = 0; entRefTrap = 0; pidIds = '0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (grantMask !== 3'b000 || faultCode !== 4'd0) begin
      bad++;
      $display("FAIL R13: mask=%b fault=%0d expected mask=000 fault=0", grantMask, faultCode);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1 privilege window with a probe on a read/write/execute page
    for (int p = 0; p < 4; p++) begin
      v = baseVec(); v.kind = 2'd0; v.priv = p[1:0]; v.pl1 = 2'd2; v.pl2 = 2'd1;
      apply(v, "R1");
    end
    // R2 type sweep
    for (int t = 0; t < 8; t++) begin
      v = baseVec(); v.kind = 2'd0; v.typ = t[2:0]; v.priv = 2'd1; v.pl1 = 2'd2; v.pl2 = 2'd1;
      apply(v, "R2");
    end
    // R3 misses
    v = baseVec(); v.hit = 0; v.kind = 2'd3; apply(v, "R3");
    v = baseVec(); v.hit = 0; v.kind = 2'd1; apply(v, "R3");
    v = baseVec(); v.hit = 0; v.kind = 2'd0; apply(v, "R3");
    // R4 probe ignores faulty flags
    v = baseVec(); v.kind = 2'd0; v.d = 0; v.b = 1; v.t = 1; v.en = 1; v.aid = 31'h1234;
    apply(v, "R4");
    // R5 check skipped
    v = baseVec(); v.kind = 2'd2; v.en = 1; v.aid = 31'd0; apply(v, "R5");
    v = baseVec(); v.kind = 2'd2; v.en = 0; v.aid = 31'h1234; apply(v, "R5");
    // R6 write-disable and first match
    v = baseVec(); v.kind = 2'd2; v.en = 1; v.aid = 31'h7FFF1234;
    v = setId(v, 4, 16'h1234, 1'b1); apply(v, "R6");
    v.kind = 2'd1; apply(v, "R6");
    v = baseVec(); v.kind = 2'd2; v.en = 1; v.aid = 31'h1234;
    v = setId(v, 2, 16'h1234, 1'b1); v = setId(v, 6, 16'h1234, 1'b0); apply(v, "R6");
    // R7 high halves
    v = baseVec(); v.kind = 2'd1; v.en = 1; v.aid = 31'h0BEEF;
    v = setId(v, 1, 16'hBEEF, 1'b0); v.wide = 1; apply(v, "R7");
    v.wide = 0; apply(v, "R7");
    v = baseVec(); v.kind = 2'd2; v.en = 1; v.aid = 31'h0BEEF;
    v = setId(v, 1, 16'hBEEF, 1'b1); v = setId(v, 2, 16'hBEEF, 1'b0);
    v.wide = 1; apply(v, "R7");
    v.wide = 0; apply(v, "R7");
    // R8 execute denied by identifiers
    v = baseVec(); v.kind = 2'd3; v.en = 1; v.aid = 31'h55; apply(v, "R8");
    // R9 rights faults
    v = baseVec(); v.typ = 3'd0; v.kind = 2'd2; apply(v, "R9");
    v = baseVec(); v.typ = 3'd1; v.kind = 2'd3; apply(v, "R9");
    // R10 dirty
    v = baseVec(); v.kind = 2'd2; v.d = 0; apply(v, "R10");
    v.kind = 2'd1; apply(v, "R10");
    // R11 break overrides dirty
    v = baseVec(); v.kind = 2'd2; v.d = 0; v.b = 1; apply(v, "R11");
    // R12 reference trap
    v = baseVec(); v.kind = 2'd2; v.d = 0; v.b = 1; v.t = 1; apply(v, "R12");
    v = baseVec(); v.kind = 2'd3; v.typ = 3'd2; v.t = 1; v.priv = 2'd3; apply(v, "R12");

    // randomized against the model
    for (int n = 0; n < 500; n++) begin
      logic [31:0] r0, r1;
      r0 = $urandom(); r1 = $urandom();
      v = baseVec();
      v.hit = r0[0] | r0[1]; v.kind = r0[3:2]; v.priv = r0[5:4]; v.en = r0[6];
      v.wide = r0[7]; v.typ = r0[10:8]; v.pl1 = r0[12:11]; v.pl2 = r0[14:13];
      v.d = r0[15]; v.b = r0[16] & r0[17]; v.t = r0[18] & r0[19];
      v.aid = r0[20] ? 31'd0 : {r1[30:20], 12'h000, r1[3:0]};
      for (int s = 0; s < SLOTS; s++) begin
        logic [31:0] r2;
        r2 = $urandom();
        v = setId(v, s, {12'h000, r2[3:0]}, r2[4]);
      end
      apply(v, "");
    end

    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule